// File: doc/BRIEF.md
# DMA Trigger Source Selector

This block picks and conditions the start request for each DMA channel. Every channel has a 4-bit select code that chooses one of sixteen sources:
- a per-channel software request bit
- eleven peripheral event flags (timer compare, serial receive and transmit, DAC)
- the ADC completion strobe
- the multiplier's operand-ready line
- the completion flag of the preceding channel
- an external request pin

A channel fires a one-cycle trigger on the rising edge of its gated source condition. A peripheral flag is masked while its interrupt enable is set, because the CPU then owns that event.

When the transfer engine reports that a channel's transfer starts, the block returns a clear strobe to the flag or request bit that caused the trigger. The chained completion flags, the external pin and the multiplier line are never cleared here. ADC flags are cleared only by the engine's read of a result register, which the block decodes. Address generation, arbitration and the transfer itself live elsewhere.

Top module: `dma_trig_sel`

## Requirements
- R1: After reset, trig_o, flag_clr_o, sw_clr_o and adc_clr_o are all zero.
- R2: trig_o[c] goes high for exactly one cycle after the first clock edge at which the channel's gated source is high and was low at the previous edge. A source held high gives one trigger, and it re-arms only after it has fallen and risen again.
- R3: Select codes map to flag_i bits as follows: 1→0, 2→1, 3→2, 4→3, 5→4, 7→5, 8→6, 9→7, 10→8, 12→9, 13→10. A flag whose flag_ie_i bit is set produces no trigger.
- R4: While a channel owes a clear for a flag source, raising xfer_start_i[c] pulses flag_clr_o at that source's bit in the same cycle (combinational).
- R5: Code 0 triggers from sw_req_i[c]. The start of that transfer pulses sw_clr_o[c] in the same cycle.
- R6: Code 14 triggers channel c from done_i[(c-1) mod NUM_CH]; channel 0 follows the last channel. Transfer start produces no clear.
- R7: Code 15 triggers from ext_req_i and code 11 from mul_rdy_i. Neither produces any clear at transfer start.
- R8: Code 6 triggers from adc_eoc_i at index adc_chan_i when adc_seq_i is 0, and at index adc_last_i when it is 1. Strobes at other indexes do not trigger. Transfer start produces no clear.
- R9: adc_rd_i pulses adc_clr_o at bit adc_rd_idx_i in the same cycle. Otherwise adc_clr_o is zero.
- R10: A change of a channel's select code drops any clear it owes and suppresses a trigger at that edge. If the new source is high at the next edge, it triggers.
- R11: Channels that select the same flag each get their own trigger. The flag is cleared only at the first of their transfer starts; later starts issue no clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 4*NUM_CH | Select code per channel, channel c at bits 4c+3:4c |
| sw_req_i | input | NUM_CH | Software request bit per channel |
| sw_clr_o | output | NUM_CH | Clear strobe to the software request bit |
| flag_i | input | 11 | Peripheral event flags |
| flag_ie_i | input | 11 | Interrupt enables matching flag_i |
| flag_clr_o | output | 11 | Clear strobes to the peripheral flags |
| mul_rdy_i | input | 1 | Multiplier ready for a new operand |
| adc_eoc_i | input | ADC_N | Hardware conversion-complete strobe per ADC result |
| adc_seq_i | input | 1 | ADC sequence mode |
| adc_chan_i | input | log2(ADC_N) | ADC channel used in single mode |
| adc_last_i | input | log2(ADC_N) | Last conversion of the sequence |
| adc_rd_i | input | 1 | DMA reads an ADC result |
| adc_rd_idx_i | input | log2(ADC_N) | Index of the result read |
| adc_clr_o | output | ADC_N | Clear strobes to the ADC flags |
| done_i | input | NUM_CH | Channel completion flags |
| ext_req_i | input | 1 | External request pin |
| xfer_start_i | input | NUM_CH | Transfer start per channel |
| trig_o | output | NUM_CH | One-cycle trigger per channel |

## Verification
Each channel holds three pieces of state: the stored select code, the previous source level and a clear-owed bit.

A wrong select copy or level history shows at trig_o as a missing, doubled or stretched pulse one edge after the stimulus. A wrong clear-owed bit does not show until the next transfer start. It then appears in that same cycle as a missing clear, a spurious clear or a duplicated clear on flag_clr_o or sw_clr_o. For that reason the tests always follow a trigger with a start, and also issue starts after select changes and after shared triggers.

// File: rtl/dma_trig_pkg.sv
`timescale 1ns/1ps
package dma_trig_pkg;
   localparam int          CODE_W = 4;
   localparam int          NFLAG  = 11;
   localparam logic [3:0]  C_SW    = 4'd0;
   localparam logic [3:0]  C_ADC   = 4'd6;
   localparam logic [3:0]  C_MUL   = 4'd11;
   localparam logic [3:0]  C_CHAIN = 4'd14;
   localparam logic [3:0]  C_EXT   = 4'd15;

   // flag bit driven by a select code, -1 when the code is not a flag source
   function automatic int flag_bit(input logic [3:0] code);
      case (code)
         4'd1:    return 0;
         4'd2:    return 1;
         4'd3:    return 2;
         4'd4:    return 3;
         4'd5:    return 4;
         4'd7:    return 5;
         4'd8:    return 6;
         4'd9:    return 7;
         4'd10:   return 8;
         4'd12:   return 9;
         4'd13:   return 10;
         default: return -1;
      endcase
   endfunction
endpackage

// File: rtl/dma_trig_adc.sv
`timescale 1ns/1ps
module dma_trig_adc #(
   parameter int ADC_N = 16,
   localparam int AW = $clog2(ADC_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ADC_N-1:0] eoc_i,
   input  logic             seq_i,
   input  logic [AW-1:0]    chan_i,
   input  logic [AW-1:0]    last_i,
   input  logic             rd_i,
   input  logic [AW-1:0]    rd_idx_i,
   output logic             hit_o,
   output logic [ADC_N-1:0] clr_o
);
   logic [AW-1:0] pick;

   always_comb begin
      pick  = seq_i ? last_i : chan_i;
      hit_o = 1'b0;
      clr_o = '0;
      for (int i = 0; i < ADC_N; i++) begin
         if (pick == AW'(i))                hit_o    = eoc_i[i];
         if (rd_i && (rd_idx_i == AW'(i)))  clr_o[i] = 1'b1;
      end
   end

   // R9
   adc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_o) |-> (rd_i && $countones(clr_o) == 1));
endmodule

// File: rtl/dma_trig_ch.sv
`timescale 1ns/1ps
module dma_trig_ch
   import dma_trig_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       sel_i,
   input  logic             sw_req_i,
   input  logic [NFLAG-1:0] flag_i,
   input  logic [NFLAG-1:0] flag_ie_i,
   input  logic             mul_rdy_i,
   input  logic             adc_hit_i,
   input  logic             chain_i,
   input  logic             ext_i,
   input  logic             start_i,
   input  logic [NFLAG-1:0] clr_seen_i,
   output logic             trig_o,
   output logic             sw_clr_o,
   output logic [NFLAG-1:0] flag_clr_o
);
   logic [3:0]       sel_q;
   logic             prev_q, trig_q, owe_q;
   logic             lvl, sel_chg, rise, fire, seen, clearable;
   logic [NFLAG-1:0] mask;

   always_comb begin
      for (int i = 0; i < NFLAG; i++) mask[i] = (flag_bit(sel_i) == i);
      case (sel_i)
         C_SW:    lvl = sw_req_i;
         C_ADC:   lvl = adc_hit_i;
         C_MUL:   lvl = mul_rdy_i;
         C_CHAIN: lvl = chain_i;
         C_EXT:   lvl = ext_i;
         default: lvl = |(mask & flag_i & ~flag_ie_i);
      endcase
      sel_chg    = (sel_i != sel_q);
      rise       = lvl & ~prev_q & ~sel_chg;
      clearable  = (sel_i == C_SW) | (|mask);
      fire       = start_i & owe_q & ~sel_chg;
      seen       = |(clr_seen_i & mask);
      flag_clr_o = fire ? mask : '0;
      sw_clr_o   = fire & (sel_i == C_SW);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= C_SW;
         prev_q <= 1'b0;
         trig_q <= 1'b0;
         owe_q  <= 1'b0;
      end else begin
         sel_q  <= sel_i;
         prev_q <= sel_chg ? 1'b0 : lvl;
         trig_q <= rise;
         if (sel_chg)                owe_q <= 1'b0;
         else if (rise && clearable) owe_q <= 1'b1;
         else if (fire || seen)      owe_q <= 1'b0;
      end
   end

   assign trig_o = trig_q;

   // R2
   trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_q |=> !trig_q);
   // R10
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i != sel_q) |=> !trig_q);
   // R4
   clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|flag_clr_o) |-> (start_i && $countones(flag_clr_o) == 1));
   // R7
   noclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == C_ADC || sel_i == C_MUL || sel_i == C_CHAIN || sel_i == C_EXT)
      |-> (flag_clr_o == '0 && !sw_clr_o));
endmodule

// File: rtl/dma_trig_sel.sv
`timescale 1ns/1ps
module dma_trig_sel
   import dma_trig_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int ADC_N  = 16,
   localparam int AW    = $clog2(ADC_N)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [CODE_W*NUM_CH-1:0] sel_i,
   input  logic [NUM_CH-1:0]        sw_req_i,
   output logic [NUM_CH-1:0]        sw_clr_o,
   input  logic [NFLAG-1:0]         flag_i,
   input  logic [NFLAG-1:0]         flag_ie_i,
   output logic [NFLAG-1:0]         flag_clr_o,
   input  logic                     mul_rdy_i,
   input  logic [ADC_N-1:0]         adc_eoc_i,
   input  logic                     adc_seq_i,
   input  logic [AW-1:0]            adc_chan_i,
   input  logic [AW-1:0]            adc_last_i,
   input  logic                     adc_rd_i,
   input  logic [AW-1:0]            adc_rd_idx_i,
   output logic [ADC_N-1:0]         adc_clr_o,
   input  logic [NUM_CH-1:0]        done_i,
   input  logic                     ext_req_i,
   input  logic [NUM_CH-1:0]        xfer_start_i,
   output logic [NUM_CH-1:0]        trig_o
);
   if (NUM_CH < 2) begin : g_bad_ch
      $error("dma_trig_sel: NUM_CH must be at least 2 for chaining");
   end
   if (ADC_N < 2) begin : g_bad_adc
      $error("dma_trig_sel: ADC_N must be at least 2");
   end

   logic             adc_hit;
   logic [NFLAG-1:0] clr_ch [NUM_CH];

   dma_trig_adc #(.ADC_N(ADC_N)) i_adc (
      .clk(clk), .rst_n(rst_n), .eoc_i(adc_eoc_i), .seq_i(adc_seq_i),
      .chan_i(adc_chan_i), .last_i(adc_last_i), .rd_i(adc_rd_i),
      .rd_idx_i(adc_rd_idx_i), .hit_o(adc_hit), .clr_o(adc_clr_o)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      localparam int PREV = (g + NUM_CH - 1) % NUM_CH;
      dma_trig_ch i_ch (
         .clk(clk), .rst_n(rst_n),
         .sel_i(sel_i[CODE_W*g +: CODE_W]),
         .sw_req_i(sw_req_i[g]), .flag_i(flag_i), .flag_ie_i(flag_ie_i),
         .mul_rdy_i(mul_rdy_i), .adc_hit_i(adc_hit), .chain_i(done_i[PREV]),
         .ext_i(ext_req_i), .start_i(xfer_start_i[g]), .clr_seen_i(flag_clr_o),
         .trig_o(trig_o[g]), .sw_clr_o(sw_clr_o[g]), .flag_clr_o(clr_ch[g])
      );
   end

   always_comb begin
      flag_clr_o = '0;
      for (int c = 0; c < NUM_CH; c++) flag_clr_o = flag_clr_o | clr_ch[c];
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (trig_o == '0));
endmodule

// File: tb/test_dma_trig_sel.sv
`timescale 1ns/1ps
module test_dma_trig_sel;
   localparam int NC = 3;
   localparam int AN = 16;
   logic clk = 1'b0, rst_n = 1'b0;
   logic [4*NC-1:0] sel = '0;
   logic [NC-1:0] sw_req = '0, sw_clr, done = '0, start = '0, trig;
   logic [10:0] flag = '0, ie = '0, flag_clr;
   logic mul = 1'b0, ext = 1'b0, aseq = 1'b0, ard = 1'b0;
   logic [AN-1:0] eoc = '0, aclr;
   logic [3:0] achan = '0, alast = '0, aridx = '0;
   int checks = 0, fails = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   dma_trig_sel i_dma_trig_sel (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .sw_req_i(sw_req), .sw_clr_o(sw_clr),
      .flag_i(flag), .flag_ie_i(ie), .flag_clr_o(flag_clr), .mul_rdy_i(mul),
      .adc_eoc_i(eoc), .adc_seq_i(aseq), .adc_chan_i(achan), .adc_last_i(alast),
      .adc_rd_i(ard), .adc_rd_idx_i(aridx), .adc_clr_o(aclr), .done_i(done),
      .ext_req_i(ext), .xfer_start_i(start), .trig_o(trig)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic set_sel(input int ch, input logic [3:0] code);
      sel[4*ch +: 4] = code;
      tick(); tick();
   endtask

   task automatic t_reset();
      chk("R1 trig", 32'(trig), 0);
      chk("R1 flag_clr", 32'(flag_clr), 0);
      chk("R1 sw_clr", 32'(sw_clr), 0);
      chk("R1 adc_clr", 32'(aclr), 0);
   endtask

   task automatic t_flags();
      int codes [11] = '{1, 2, 3, 4, 5, 7, 8, 9, 10, 12, 13};
      set_sel(0, 4'd1);
      flag[0] = 1'b1; tick();
      chk("R2 first pulse", 32'(trig), 1);
      tick();
      chk("R2 held source one pulse", 32'(trig), 0);
      start[0] = 1'b1; #1;
      chk("R4 clear at start", 32'(flag_clr), 1);
      tick(); start[0] = 1'b0; flag[0] = 1'b0; tick();
      flag[0] = 1'b1; tick();
      chk("R2 re-arm", 32'(trig), 1);
      start[0] = 1'b1; tick(); start[0] = 1'b0; flag[0] = 1'b0; tick();
      for (int k = 0; k < 11; k++) begin
         set_sel(0, 4'(codes[k]));
         flag[k] = 1'b1; tick();
         chk("R3 code map trigger", 32'(trig), 1);
         start[0] = 1'b1; #1;
         chk("R4 code map clear", 32'(flag_clr), 32'(1 << k));
         tick(); start[0] = 1'b0; flag[k] = 1'b0; tick();
      end
   endtask

   task automatic t_gate();
      set_sel(0, 4'd5);
      ie[4] = 1'b1; flag[4] = 1'b1; tick(); tick();
      chk("R3 enable masks flag", 32'(trig), 0);
      ie[4] = 1'b0; tick();
      chk("R3 enable dropped", 32'(trig), 1);
      start[0] = 1'b1; tick(); start[0] = 1'b0; flag[4] = 1'b0; tick();
   endtask

   task automatic t_sw();
      set_sel(1, 4'd0);
      sw_req[1] = 1'b1; tick();
      chk("R5 sw trigger", 32'(trig), 32'b010);
      start[1] = 1'b1; #1;
      chk("R5 sw clear", 32'(sw_clr), 32'b010);
      tick(); start[1] = 1'b0; sw_req[1] = 1'b0; tick();
   endtask

   task automatic t_chain();
      sel = {4'd14, 4'd14, 4'd14}; tick(); tick();
      done[0] = 1'b1; tick();
      chk("R6 ch0 done -> ch1", 32'(trig), 32'b010);
      done[2] = 1'b1; tick();
      chk("R6 ch2 done -> ch0", 32'(trig), 32'b001);
      done[1] = 1'b1; tick();
      chk("R6 ch1 done -> ch2", 32'(trig), 32'b100);
      start = 3'b111; #1;
      chk("R6 no clear", 32'({flag_clr, sw_clr}), 0);
      tick(); start = '0; done = '0; tick();
   endtask

   task automatic t_ext_mul();
      sel = {4'd11, 4'd14, 4'd15}; tick(); tick();
      ext = 1'b1; tick();
      chk("R7 external", 32'(trig), 32'b001);
      mul = 1'b1; tick();
      chk("R7 multiplier", 32'(trig), 32'b100);
      tick();
      chk("R7 held lines no retrigger", 32'(trig), 0);
      start = 3'b101; #1;
      chk("R7 no clear", 32'({flag_clr, sw_clr}), 0);
      tick(); start = '0; ext = 1'b0; mul = 1'b0; tick();
   endtask

   task automatic t_adc();
      set_sel(0, 4'd6);
      aseq = 1'b0; achan = 4'd3; alast = 4'd7;
      eoc[5] = 1'b1; tick(); eoc[5] = 1'b0;
      chk("R8 other index ignored", 32'(trig), 0);
      tick();
      eoc[3] = 1'b1; tick(); eoc[3] = 1'b0;
      chk("R8 single channel", 32'(trig), 32'b001);
      tick(); aseq = 1'b1;
      eoc[3] = 1'b1; tick(); eoc[3] = 1'b0;
      chk("R8 seq ignores non-last", 32'(trig), 0);
      tick();
      eoc[7] = 1'b1; tick(); eoc[7] = 1'b0;
      chk("R8 seq last", 32'(trig), 32'b001);
      start[0] = 1'b1; #1;
      chk("R8 no clear at start", 32'({aclr, flag_clr}), 0);
      tick(); start[0] = 1'b0;
      ard = 1'b1; aridx = 4'd7; #1;
      chk("R9 read clears", 32'(aclr), 32'(1 << 7));
      tick(); ard = 1'b0; #1;
      chk("R9 idle", 32'(aclr), 0);
      tick();
   endtask

   task automatic t_selchg();
      set_sel(0, 4'd1);
      flag[0] = 1'b1; tick();
      chk("R10 setup trigger", 32'(trig), 1);
      flag[5] = 1'b1;
      sel[3:0] = 4'd7; tick();
      chk("R10 no trigger at change", 32'(trig), 0);
      tick();
      chk("R10 new source triggers", 32'(trig), 1);
      sel[3:0] = 4'd12; tick(); tick();
      start[0] = 1'b1; #1;
      chk("R10 stale clear dropped", 32'(flag_clr), 0);
      tick(); start[0] = 1'b0;
      flag[9] = 1'b1; tick();
      chk("R10 fresh source", 32'(trig), 1);
      flag = '0; start[0] = 1'b1; tick(); start[0] = 1'b0; tick();
   endtask

   task automatic t_shared();
      sel = {4'd0, 4'd3, 4'd3}; tick(); tick();
      flag[2] = 1'b1; tick();
      chk("R11 both trigger", 32'(trig), 32'b011);
      start[0] = 1'b1; #1;
      chk("R11 first start clears", 32'(flag_clr), 32'(1 << 2));
      tick(); start[0] = 1'b0; flag[2] = 1'b0; tick();
      start[1] = 1'b1; #1;
      chk("R11 second start silent", 32'(flag_clr), 0);
      tick(); start[1] = 1'b0; tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_flags();
      t_gate();
      t_sw();
      t_chain();
      t_ext_mul();
      t_adc();
      t_selchg();
      t_shared();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule